// File: doc/BRIEF.md
# Interrupt Flag and Wake-Up Controller

This block gathers six maskable event sources and one non-maskable tick for a small CPU. The sources are a fix-time tick, timer 1, port-1 pins, timer 2, sound generator 1 and sound generator 2. Each event latches into a flag register that software can read. Writing a 0 to a flag clears it, and writing a 1 leaves it as it is. Per-source enables decide whether an event latches and whether a latched flag drives the level interrupt line. The 64 Hz tick becomes a one-cycle non-maskable pulse, but only when its enable is set.

The fix-time tick is made inside the block from a base pulse (the fast rate). A select bit picks either every base pulse or every second one. The port-1 event is a level condition: any pin that is wake-enabled, configured as an input and held low raises it. This level can wake the chip even while the port-1 interrupt is masked.

A power-state machine has four states: RUN, STANDBY, SLEEP2 and SLEEP1. It leaves RUN on a command. It returns to RUN on a wake condition whose allowed sources shrink as the sleep gets deeper. The transitions are:

- RUN→STANDBY, RUN→SLEEP2 and RUN→SLEEP1 on command codes 1, 2 and 3.
- STANDBY→RUN on any interrupt.
- SLEEP2→RUN on the NMI, the fix-time flag or port-1 wake.
- SLEEP1→RUN on port-1 wake only.

The block raises a wake request for exactly the cycle in which such a return is taken.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset all flags are 0, the interrupt line, NMI pulse and wake request are low, the power state is RUN (code 0), and the fix-time select is 1 (slow rate).
- R2: Flag bit positions are fix-time 0, timer 1 at 1, port 1 at 2, timer 2 at 3, sound 1 at 4 and sound 2 at 5. An event sets its flag at the next clock edge. Fix-time, timer 1, port 1 and timer 2 latch only while their enables are 1. Sound events always latch.
- R3: A write to the flag register (select 0) clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. An event in the same cycle as its clear leaves the flag set.
- R4: The interrupt line is high exactly while some flag is set and that flag's enable is 1. The enables are control bit 6 (fix-time), bit 1 (timer 1), bit 0 (port 1) and bit 5 (timer 2). Sound flags are always enabled. The control register is select 1.
- R5: The port-1 wake level is high while any pin has its wake-enable bit at 1 (select 2), its direction input at 0 (input) and its pin value at 0.
- R6: With control bit 0 at 0, the port-1 level sets no flag and raises no interrupt, but it still wakes the chip.
- R7: A 64 Hz tick gives a one-cycle NMI pulse in the following cycle when control bit 2 is 1, and no pulse when it is 0.
- R8: The fix-time select (select 3, data bit 0) at 0 makes every base pulse a fix-time event. At 1, every second base pulse is one.
- R9: In RUN, a nonzero power command (1 standby, 2 sleep 2, 3 sleep 1) moves the state to that code at the next edge. Commands in other states are ignored.
- R10: In STANDBY, the interrupt line, the NMI pulse or the port-1 wake level wakes the chip.
- R11: In SLEEP2, only the NMI pulse, the enabled fix-time flag or the port-1 wake level wakes the chip. Other pending interrupts do not.
- R12: In SLEEP1, only the port-1 wake level wakes the chip.
- R13: The wake request is high in exactly the cycles where the state is not RUN and that state's wake condition holds. The state is RUN at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 flags, 1 control, 2 port wake enables, 3 tick select |
| wr_data_i | input | 8 | Write data |
| base_tick_i | input | 1 | Fast-rate base pulse for the fix-time tick |
| nmi_tick_i | input | 1 | 64 Hz tick pulse |
| tmr1_evt_i | input | 1 | Timer 1 event pulse |
| tmr2_evt_i | input | 1 | Timer 2 event pulse |
| snd1_evt_i | input | 1 | Sound generator 1 event pulse |
| snd2_evt_i | input | 1 | Sound generator 2 event pulse |
| p1_pin_i | input | 8 | Port-1 pin levels |
| p1_out_dir_i | input | 8 | Port-1 direction, 1 = output |
| pwr_cmd_i | input | 2 | Power command: 0 none, 1 standby, 2 sleep 2, 3 sleep 1 |
| flags_o | output | 6 | Flag register contents |
| irq_o | output | 1 | Level interrupt request |
| nmi_o | output | 1 | One-cycle NMI pulse |
| wake_o | output | 1 | Wake request |
| pwr_state_o | output | 2 | Power state: 0 RUN, 1 STANDBY, 2 SLEEP2, 3 SLEEP1 |

## Verification
Random event, write and pin patterns run against a cycle model. This separates the gating of flag setting from the gating of the interrupt line, because enables change while flags are pending. Directed cases do three things:
- They place a clear and an event on the same bit in one cycle, to show the set has priority over the clear.
- They count fix-time events over four base pulses at each select value.
- They enter each sleep depth and offer it a source it must ignore before one it must accept, which tells the three wake tables apart.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
    typedef enum logic [1:0] {
        PWR_RUN     = 2'd0,
        PWR_STANDBY = 2'd1,
        PWR_SLEEP2  = 2'd2,
        PWR_SLEEP1  = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_PWAKE = 2'd2,
        SEL_TICK  = 2'd3
    } reg_sel_e;

    localparam int NSRC    = 6;
    localparam int SRC_FIX = 0;
    localparam int SRC_T1  = 1;
    localparam int SRC_P1  = 2;
    localparam int SRC_T2  = 3;
    localparam int SRC_SG1 = 4;
    localparam int SRC_SG2 = 5;

    localparam int EN_P1  = 0;
    localparam int EN_T1  = 1;
    localparam int EN_NMI = 2;
    localparam int EN_T2  = 5;
    localparam int EN_FIX = 6;
endpackage

// File: rtl/irqw_fix_tick.sv
module irqw_fix_tick #(
    parameter int SLOW_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick_i,
    input  logic slow_i,
    output logic evt_o
);
    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (base_tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign evt_o = base_tick_i && (!slow_i || (cnt_q == LAST));

    // R8: a slow-rate event never comes without a base pulse
    a_r8_evt_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> base_tick_i);
endmodule

// File: rtl/irqw_flag_bank.sv
module irqw_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         wr_i,
    input  logic [N-1:0] wr_keep_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    logic [N-1:0] flags_q;
    logic [N-1:0] keep;

    assign keep = wr_i ? wr_keep_i : '1;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & keep) | set_i;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & en_i);

    // R3: without a flag write no flag is lost
    a_r3_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            // R3: a zero written with no event clears the bit
            a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_i && !wr_keep_i[g] && !set_i[g]) |=> !flags_o[g]);
            // R2: an event always leaves its flag set
            a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[g] |=> flags_o[g]);
        end
    endgenerate
endmodule

// File: rtl/irqw_pwr_fsm.sv
module irqw_pwr_fsm
    import irqw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd_i,
    input  logic       irq_i,
    input  logic       nmi_i,
    input  logic       fix_i,
    input  logic       p1_i,
    output logic [1:0] state_o,
    output logic       wake_o
);
    pwr_state_e state_q, state_d;
    logic       cond;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        cond   = 1'b0;
        wake_o = 1'b0;
        unique case (state_q)
            PWR_RUN:     cond = 1'b0;
            PWR_STANDBY: cond = irq_i || nmi_i || p1_i;
            PWR_SLEEP2:  cond = nmi_i || fix_i || p1_i;
            PWR_SLEEP1:  cond = p1_i;
        endcase
        wake_o = cond;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:     if (cmd_i != 2'd0) state_d = pwr_state_e'(cmd_i);
            PWR_STANDBY,
            PWR_SLEEP2,
            PWR_SLEEP1:  if (cond) state_d = PWR_RUN;
        endcase
    end

    assign state_o = state_q;

    // R9: a command taken in RUN selects that state
    a_r9_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && cmd_i != 2'd0) |=> (state_o == $past(cmd_i)));
    // R13: a wake request returns to RUN
    a_r13_wake_run: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> (state_o == 2'd0));
    // R12: deep sleep is held while port 1 is quiet
    a_r12_sleep1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && !p1_i) |=> (state_o == 2'd3));
    // R13: no wake request in RUN
    a_r13_none_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> !wake_o);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import irqw_pkg::*;
#(
    parameter int DW       = 8,
    parameter int P1_W     = 8,
    parameter int SLOW_DIV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [1:0]      wr_sel_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic            base_tick_i,
    input  logic            nmi_tick_i,
    input  logic            tmr1_evt_i,
    input  logic            tmr2_evt_i,
    input  logic            snd1_evt_i,
    input  logic            snd2_evt_i,
    input  logic [P1_W-1:0] p1_pin_i,
    input  logic [P1_W-1:0] p1_out_dir_i,
    input  logic [1:0]      pwr_cmd_i,
    output logic [NSRC-1:0] flags_o,
    output logic            irq_o,
    output logic            nmi_o,
    output logic            wake_o,
    output logic [1:0]      pwr_state_o
);
    logic            en_fix_q, en_t1_q, en_p1_q, en_t2_q, en_nmi_q;
    logic [P1_W-1:0] pwake_q;
    logic            slow_q;
    logic            nmi_q;
    logic            fix_evt, p1_low;
    logic            wr_flags;
    logic [NSRC-1:0] set_vec, en_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_fix_q <= 1'b0;
            en_t1_q  <= 1'b0;
            en_p1_q  <= 1'b0;
            en_t2_q  <= 1'b0;
            en_nmi_q <= 1'b0;
            pwake_q  <= '0;
            slow_q   <= 1'b1;
            nmi_q    <= 1'b0;
        end else begin
            nmi_q <= nmi_tick_i && en_nmi_q;
            if (wr_en_i) begin
                unique case (reg_sel_e'(wr_sel_i))
                    SEL_FLAGS: ;
                    SEL_CTRL: begin
                        en_fix_q <= wr_data_i[EN_FIX];
                        en_t1_q  <= wr_data_i[EN_T1];
                        en_p1_q  <= wr_data_i[EN_P1];
                        en_t2_q  <= wr_data_i[EN_T2];
                        en_nmi_q <= wr_data_i[EN_NMI];
                    end
                    SEL_PWAKE: pwake_q <= wr_data_i[P1_W-1:0];
                    SEL_TICK:  slow_q  <= wr_data_i[0];
                endcase
            end
        end
    end

    irqw_fix_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_tick_i (base_tick_i),
        .slow_i      (slow_q),
        .evt_o       (fix_evt)
    );

    assign p1_low   = |(pwake_q & ~p1_out_dir_i & ~p1_pin_i);
    assign wr_flags = wr_en_i && (wr_sel_i == SEL_FLAGS);

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_FIX] = fix_evt && en_fix_q;
        set_vec[SRC_T1]  = tmr1_evt_i && en_t1_q;
        set_vec[SRC_P1]  = p1_low && en_p1_q;
        set_vec[SRC_T2]  = tmr2_evt_i && en_t2_q;
        set_vec[SRC_SG1] = snd1_evt_i;
        set_vec[SRC_SG2] = snd2_evt_i;
        en_vec           = '1;
        en_vec[SRC_FIX]  = en_fix_q;
        en_vec[SRC_T1]   = en_t1_q;
        en_vec[SRC_P1]   = en_p1_q;
        en_vec[SRC_T2]   = en_t2_q;
    end

    irqw_flag_bank #(.N(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .wr_i      (wr_flags),
        .wr_keep_i (wr_data_i[NSRC-1:0]),
        .en_i      (en_vec),
        .flags_o   (flags_o),
        .irq_o     (irq_o)
    );

    assign nmi_o = nmi_q;

    irqw_pwr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (pwr_cmd_i),
        .irq_i   (irq_o),
        .nmi_i   (nmi_q),
        .fix_i   (flags_o[SRC_FIX] && en_fix_q),
        .p1_i    (p1_low),
        .state_o (pwr_state_o),
        .wake_o  (wake_o)
    );

    // R4: the interrupt line implies a pending flag
    a_r4_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_o != '0));
    // R7: an NMI pulse follows an enabled tick
    a_r7_nmi_src: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> $past(nmi_tick_i));
    // R6: a masked port-1 level never sets its flag
    a_r6_masked_p1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_p1_q && !wr_flags && !flags_o[SRC_P1]) |=> !flags_o[SRC_P1]);
endmodule

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       base_tick = 1'b0, nmi_tick = 1'b0;
    logic       t1 = 1'b0, t2 = 1'b0, s1 = 1'b0, s2 = 1'b0;
    logic [7:0] pins = 8'hFF, dir = 8'h00;
    logic [1:0] cmd = '0;
    logic [5:0] flags_o;
    logic       irq_o, nmi_o, wake_o;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    string ctx = "INIT";

    logic [5:0] m_flags;
    logic [7:0] m_ctrl, m_wen;
    logic       m_sel, m_cnt, m_nmi;
    logic [1:0] m_state;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .base_tick_i(base_tick), .nmi_tick_i(nmi_tick), .tmr1_evt_i(t1), .tmr2_evt_i(t2),
        .snd1_evt_i(s1), .snd2_evt_i(s2), .p1_pin_i(pins), .p1_out_dir_i(dir),
        .pwr_cmd_i(cmd), .flags_o(flags_o), .irq_o(irq_o), .nmi_o(nmi_o),
        .wake_o(wake_o), .pwr_state_o(state_o)
    );

    function automatic logic [5:0] f_mask(input logic [7:0] c);
        return {1'b1, 1'b1, c[5], c[0], c[1], c[6]};
    endfunction

    function automatic logic f_p1low(input logic [7:0] w, input logic [7:0] d, input logic [7:0] p);
        return |(w & ~d & ~p);
    endfunction

    function automatic logic f_cond(input logic [1:0] st, input logic irq, input logic nmi,
                                    input logic fix, input logic p1);
        case (st)
            2'd1:    return irq | nmi | p1;
            2'd2:    return nmi | fix | p1;
            2'd3:    return p1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h t=%0t", tag, ctx, act, exp, $time);
        end
    endtask

    task automatic cyc();
        logic       e_irq, p1l, cond, fevt;
        logic [5:0] set, keep;
        #1;
        p1l   = f_p1low(m_wen, dir, pins);
        e_irq = |(m_flags & f_mask(m_ctrl));
        cond  = f_cond(m_state, e_irq, m_nmi, m_flags[0] & m_ctrl[6], p1l);
        check("R2 flags", {2'b0, flags_o}, {2'b0, m_flags});
        check("R4 irq", {7'b0, irq_o}, {7'b0, e_irq});
        check("R7 nmi", {7'b0, nmi_o}, {7'b0, m_nmi});
        check("R9 state", {6'b0, state_o}, {6'b0, m_state});
        check("R13 wake", {7'b0, wake_o}, {7'b0, cond});
        @(posedge clk);
        fevt = base_tick & (m_sel ? m_cnt : 1'b1);
        set  = {s2, s1, t2 & m_ctrl[5], p1l & m_ctrl[0], t1 & m_ctrl[1], fevt & m_ctrl[6]};
        keep = (wr_en && wr_sel == 2'd0) ? wr_data[5:0] : 6'h3F;
        if (m_state == 2'd0) begin
            if (cmd != 2'd0) m_state = cmd;
        end else if (cond) m_state = 2'd0;
        m_flags = (m_flags & keep) | set;
        m_nmi   = nmi_tick & m_ctrl[2];
        if (base_tick) m_cnt = ~m_cnt;
        if (wr_en && wr_sel == 2'd1) m_ctrl = wr_data & 8'h67;
        if (wr_en && wr_sel == 2'd2) m_wen = wr_data;
        if (wr_en && wr_sel == 2'd3) m_sel = wr_data[0];
        @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_flags = '0; m_ctrl = '0; m_wen = '0; m_sel = 1'b1; m_cnt = 1'b0;
        m_nmi = 1'b0; m_state = '0;

        ctx = "R1";
        #1;
        check("R1 flags", {2'b0, flags_o}, 8'h00);
        check("R1 irq", {7'b0, irq_o}, 8'h00);
        check("R1 nmi", {7'b0, nmi_o}, 8'h00);
        check("R1 state", {6'b0, state_o}, 8'h00);
        check("R1 wake", {7'b0, wake_o}, 8'h00);
        @(negedge clk);

        ctx = "R8";
        wreg(2'd1, 8'h40);
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            base_tick = 1'b1; cyc(); base_tick = 1'b0;
            if (flags_o[0]) cnt++;
            wreg(2'd0, 8'h00);
        end
        check("R8 slow count", 8'(cnt), 8'd2);
        wreg(2'd3, 8'h00);
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            base_tick = 1'b1; cyc(); base_tick = 1'b0;
            if (flags_o[0]) cnt++;
            wreg(2'd0, 8'h00);
        end
        check("R8 fast count", 8'(cnt), 8'd4);

        ctx = "R2";
        wreg(2'd1, 8'h27);
        t1 = 1'b1; cyc(); t1 = 1'b0;
        check("R2 timer1 bit", {2'b0, flags_o}, 8'h02);
        ctx = "R3";
        t1 = 1'b1; wreg(2'd0, 8'h3D); t1 = 1'b0;
        check("R3 set beats clear", {7'b0, flags_o[1]}, 8'h01);
        s1 = 1'b1; wreg(2'd0, 8'h3D); s1 = 1'b0;
        check("R3 zero clears", {2'b0, flags_o}, 8'h10);
        wreg(2'd0, 8'h3F);
        check("R3 one keeps", {2'b0, flags_o}, 8'h10);
        wreg(2'd0, 8'h00);

        ctx = "R4";
        t1 = 1'b1; cyc(); t1 = 1'b0;
        wreg(2'd1, 8'h25);
        check("R4 masked flag", {7'b0, irq_o}, 8'h00);
        check("R4 flag kept", {7'b0, flags_o[1]}, 8'h01);
        wreg(2'd0, 8'h00);

        ctx = "R5";
        wreg(2'd1, 8'h01);
        wreg(2'd2, 8'h01);
        dir = 8'h01; pins = 8'hFE; cyc();
        check("R5 output pin ignored", {7'b0, flags_o[2]}, 8'h00);
        dir = 8'h00; cyc();
        check("R5 input low sets", {7'b0, flags_o[2]}, 8'h01);
        pins = 8'hFF; wreg(2'd0, 8'h00);

        ctx = "R6";
        wreg(2'd1, 8'h00);
        pins = 8'hFE; cyc();
        check("R6 no flag", {7'b0, flags_o[2]}, 8'h00);
        check("R6 no irq", {7'b0, irq_o}, 8'h00);
        pins = 8'hFF;
        cmd = 2'd1; cyc(); cmd = 2'd0;
        ctx = "R10";
        pins = 8'hFE; #1;
        check("R6 wake while masked", {7'b0, wake_o}, 8'h01);
        cyc(); pins = 8'hFF;
        check("R10 back to run", {6'b0, state_o}, 8'h00);
        wreg(2'd1, 8'h04);
        cmd = 2'd1; cyc(); cmd = 2'd0;
        nmi_tick = 1'b1; cyc(); nmi_tick = 1'b0;
        check("R10 nmi wakes standby", {7'b0, wake_o}, 8'h01);
        cyc();

        ctx = "R11";
        wreg(2'd1, 8'h06);
        cmd = 2'd2; cyc(); cmd = 2'd0;
        t1 = 1'b1; cyc(); t1 = 1'b0;
        cyc();
        check("R11 irq ignored", {6'b0, state_o}, 8'h02);
        nmi_tick = 1'b1; cyc(); nmi_tick = 1'b0;
        check("R11 nmi wakes", {7'b0, wake_o}, 8'h01);
        cyc();
        wreg(2'd0, 8'h00);

        ctx = "R12";
        cmd = 2'd3; cyc(); cmd = 2'd0;
        nmi_tick = 1'b1; s2 = 1'b1; cyc(); nmi_tick = 1'b0; s2 = 1'b0;
        cyc();
        check("R12 nmi and irq ignored", {6'b0, state_o}, 8'h03);
        cmd = 2'd1; cyc(); cmd = 2'd0;
        check("R9 command ignored asleep", {6'b0, state_o}, 8'h03);
        pins = 8'hFE; #1;
        check("R12 port wakes", {7'b0, wake_o}, 8'h01);
        cyc(); pins = 8'hFF;
        wreg(2'd0, 8'h00);

        ctx = "RND";
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            wr_en     = ($urandom_range(0, 19) == 0);
            wr_sel    = 2'($urandom_range(0, 3));
            wr_data   = 8'($urandom);
            base_tick = ($urandom_range(0, 9) == 0);
            nmi_tick  = ($urandom_range(0, 19) == 0);
            t1 = ($urandom_range(0, 9) == 0);
            t2 = ($urandom_range(0, 9) == 0);
            s1 = ($urandom_range(0, 29) == 0);
            s2 = ($urandom_range(0, 29) == 0);
            pins = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'hFF;
            if ($urandom_range(0, 49) == 0) dir = 8'($urandom);
            cmd = ($urandom_range(0, 24) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            cyc();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule